// File: doc/BRIEF.md
# Programmable Deglitch Filter Bank

This block cleans up a bank of up to 24 digital input lines before they reach readable input registers. Every line is first brought into the system clock domain by a two-flop synchronizer. After that it either passes straight through or goes through a glitch filter. Each channel selects this with its own enable bit. A filtered channel accepts a new level only after that level has been seen on every tick sample across one programmable stability interval. All channels share that one interval. A prescaler divides the system clock down to a 200 ns tick, and the divisor is a module parameter.

Software uses a byte-wide register port with a common address for writes and reads:

| Address | Write | Read |
|---------|-------|------|
| 0 to 2 | Staged 20-bit interval, low byte first. Only the low 4 bits of the top byte are kept. | Filtered state of the channels, low channels first |
| 4 to 6 | Enable mask, low channels first | 0 |
| 8 | Control strobes: bit 0 loads the staged interval, bit 1 resets the filter state | 0 |

A staged interval has no effect until bit 0 is strobed. Resetting the filter state makes every output take its current synchronized input at once. The filtered lines also leave the block as a parallel bus.

Top module: `deglitch_bank`

## Requirements
- R1: After reset, the enable mask, the staged interval and the active interval are all zero, and every output bit is 0 while the inputs are 0.
- R2: A channel whose enable bit is 0 copies its input to `dout` two to three clock cycles after the input changes, whatever the interval.
- R3: Writes to addresses 0 to 2 update only the staged interval. The active interval changes only in the cycle in which address 8 is written with bit 0 set.
- R4: The top interval byte (address 2) keeps only bits 3:0. Writing 0xF0 there contributes nothing to the interval.
- R5: Ticks come every TICK_DIV clock cycles. When the active interval is N > 0, a filtered channel takes a new input level only after N consecutive tick samples have all shown that level. The output never changes between ticks except through a bypass, a zero interval or a filter reset.
- R6: If a tick sample shows the input back at the output level, the count for that channel restarts. Runs of N-1 samples separated by one sample at the old level never change the output.
- R7: When the active interval is 0, enabled channels behave like bypassed ones.
- R8: Writing address 8 with bit 1 set loads every output with its current synchronized input in that same clock edge and clears the interval counts.
- R9: A read of address k (k = 0, 1, 2) returns the filtered state of channels 8k+7 down to 8k, with channel 8k in bit 0. Any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NUM_CH | Raw asynchronous input lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address, used for both writes and reads |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr`, combinational |
| dout | output | NUM_CH | Filtered input lines |

## Verification
The bench builds the block with all 24 channels and a 20-bit interval. It sets TICK_DIV to 2, so each tick takes two clock cycles and long filter windows stay short in simulation. It sweeps the interval from 1 to 6 with all channels filtered. For each interval it applies glitches one tick too short, restart patterns and holds long enough to settle, and it computes the expected outcome from the tick count. Further steps cover the staged-interval rule, the masking of the top byte, a mixed enable mask, a filter reset in the middle of a window, and the order of the readback bytes.

// File: rtl/deglitch_pkg.sv
// Shared register addresses and strobe positions for the deglitch filter bank.
// Assumes a 4-bit byte address and at most 24 channels / 24 interval bits.
package deglitch_pkg;
    localparam int ADDR_W      = 4;
    localparam logic [ADDR_W-1:0] A_IVAL_BASE = 4'd0;
    localparam logic [ADDR_W-1:0] A_MASK_BASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_CTRL      = 4'd8;
    localparam int CTRL_LOAD_BIT  = 0;
    localparam int CTRL_RESET_BIT = 1;
endpackage

// File: rtl/tick_gen.sv
// Tick prescaler: emits a one-cycle pulse every DIV clock cycles.
// Assumes DIV >= 1; DIV == 1 gives a tick on every cycle.
module tick_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            logic          tick_q;

            // Count up to DIV-1, then wrap and pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    tick_q <= 1'b0;
                end
            end
            assign tick = tick_q;

            assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate
endmodule

// File: rtl/din_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes the lines are independent single-bit levels.
module din_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end
    assign q = s2_q;
endmodule

// File: rtl/deglitch_chan.sv
// One filter channel. With filtering active, the output takes a new level
// only after IVAL consecutive tick samples have shown it. Bypass or IVAL == 0
// copies the input every cycle. A reset strobe loads the input directly.
// Assumes sync_in is already in the clk domain.
module deglitch_chan #(
    parameter int IW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          filt_en,
    input  logic [IW-1:0] ival,
    input  logic          clr,
    input  logic          sync_in,
    output logic          out_q
);
    logic [IW-1:0] cnt_q;
    logic          active;

    assign active = filt_en && (ival != '0);

    // Count consecutive differing tick samples and commit at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (clr || !active) begin
            out_q <= sync_in;
            cnt_q <= '0;
        end else if (tick) begin
            if (sync_in == out_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= ival - 1'b1) begin
                out_q <= sync_in;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(tick || clr || !filt_en || ival == '0));
    assert_bypass_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> out_q == $past(sync_in));
    assert_reset_loads_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> out_q == $past(sync_in));
endmodule

// File: rtl/deglitch_bank.sv
// Deglitch filter bank: byte register port, shared staged/active interval,
// per-channel enable mask, prescaled tick and one filter per channel.
// Assumes NUM_CH <= 24 and IW <= 24.
module deglitch_bank
    import deglitch_pkg::*;
#(
    parameter int NUM_CH   = 24,
    parameter int IW       = 20,
    parameter int TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] dout
);
    logic [IW-1:0]     stage_q, ival_q;
    logic [NUM_CH-1:0] mask_q, sync_v;
    logic              tick, ld_ival, clr_filt, ctrl_wr;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign ld_ival  = ctrl_wr && reg_wdata[CTRL_LOAD_BIT];
    assign clr_filt = ctrl_wr && reg_wdata[CTRL_RESET_BIT];

    // Byte writes into the staged interval and the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            mask_q  <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < IW; i++)
                if (reg_addr == A_IVAL_BASE + 4'(i / 8))
                    stage_q[i] <= reg_wdata[i % 8];
            for (int i = 0; i < NUM_CH; i++)
                if (reg_addr == A_MASK_BASE + 4'(i / 8))
                    mask_q[i] <= reg_wdata[i % 8];
        end
    end

    // Active interval takes the staged value only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       ival_q <= '0;
        else if (ld_ival) ival_q <= stage_q;
    end

    assert_ival_load_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ival_q) |-> $past(ld_ival));

    tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    din_sync #(.W(NUM_CH)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(sync_v));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            deglitch_chan #(.IW(IW)) i_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .filt_en(mask_q[c]),
                .ival   (ival_q),
                .clr    (clr_filt),
                .sync_in(sync_v[c]),
                .out_q  (dout[c]));
        end
    endgenerate

    // Read mux: filtered state bytes, low channels at the lowest address.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (reg_addr == 4'(i / 8))
                reg_rdata[i % 8] = dout[i];
    end
endmodule

// File: tb/test_deglitch_bank.sv
module test_deglitch_bank;
    localparam int NUM_CH = 24;
    localparam int DIV    = 2;
    localparam int CYC    = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] din = '0;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [NUM_CH-1:0] dout;
    int tests = 0;
    int fails = 0;
    logic [NUM_CH-1:0] ALL1 = '1;

    always #(CYC / 2) clk = ~clk;

    deglitch_bank #(.NUM_CH(NUM_CH), .IW(20), .TICK_DIV(DIV)) i_deglitch_bank (
        .clk(clk), .rst_n(rst_n), .din(din), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dout(dout));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ival(input int v);
        wr(4'd0, 8'(v)); wr(4'd1, 8'(v >> 8)); wr(4'd2, 8'((v >> 16) & 15));
        wr(4'd8, 8'h03);
    endtask

    initial begin
        #(CYC * 150000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cycles(2);
        // R1: reset state
        check("R1 dout", 32'(dout), 0);
        rd(4'd0, b); check("R1 byte0", 32'(b), 0);
        // R7/R1: zero interval with mask zero passes through
        din = 24'hA5A5A5; cycles(4);
        check("R7 passthrough", 32'(dout), 32'hA5A5A5);
        // R9: readback order
        din = 24'h3C5A96; cycles(4);
        rd(4'd0, b); check("R9 byte0", 32'(b), 32'h96);
        rd(4'd1, b); check("R9 byte1", 32'(b), 32'h5A);
        rd(4'd2, b); check("R9 byte2", 32'(b), 32'h3C);
        rd(4'd5, b); check("R9 other addr", 32'(b), 0);
        din = '0; cycles(4);

        // R3: staged interval without load has no effect
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'hFF);
        wr(4'd0, 8'd6);
        din = ALL1; cycles(4);
        check("R3 staged not active", 32'(dout), 32'(ALL1));
        din = '0; cycles(4);
        check("R7 enabled zero interval", 32'(dout), 0);
        wr(4'd8, 8'h01);
        din = ALL1; cycles(5 * DIV); din = '0; cycles(4);
        check("R3 loaded interval filters", 32'(dout), 0);

        // R5/R6: sweep of intervals with all channels filtered
        for (int n = 1; n <= 6; n++) begin
            set_ival(n);
            din = '0; cycles(4);
            if (n > 1) begin
                din = ALL1; cycles((n - 1) * DIV); din = '0; cycles(4);
                check($sformatf("R5 short glitch n=%0d", n), 32'(dout), 0);
            end
            din = ALL1; cycles((n + 1) * DIV + 4);
            check($sformatf("R5 long hold n=%0d", n), 32'(dout), 32'(ALL1));
            if (n > 1) begin
                din = '0; cycles((n - 1) * DIV);
                din = ALL1; cycles(DIV);
                din = '0; cycles((n - 1) * DIV);
                din = ALL1; cycles(4);
                check($sformatf("R6 restart n=%0d", n), 32'(dout), 32'(ALL1));
            end
            din = '0; cycles((n + 1) * DIV + 4);
            check($sformatf("R5 fall n=%0d", n), 32'(dout), 0);
        end

        // R4: top byte high nibble ignored -> interval 3
        wr(4'd0, 8'd3); wr(4'd1, 8'd0); wr(4'd2, 8'hF0); wr(4'd8, 8'h01);
        din = ALL1; cycles(4 * DIV + 4);
        check("R4 top nibble masked", 32'(dout), 32'(ALL1));
        din = '0; cycles(4 * DIV + 4);

        // R2: mixed mask, channel 0 filtered, others bypassed
        set_ival(4);
        wr(4'd4, 8'h01); wr(4'd5, 8'h00); wr(4'd6, 8'h00);
        din = ALL1; cycles(3);
        check("R2 bypass follows", 32'(dout), 32'(ALL1 & ~24'h1));
        din = '0; cycles(4);
        check("R2 filtered ignores", 32'(dout), 0);

        // R8: filter reset loads input mid-window
        set_ival(20);
        din = 24'h000001; cycles(6);
        check("R8 before reset", 32'(dout), 0);
        wr(4'd8, 8'h02);
        check("R8 after reset", 32'(dout), 32'h1);
        din = '0; cycles(6);
        check("R8 still filtered", 32'(dout), 32'h1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule